// File: doc/BRIEF.md
# Coarse-Clock Oldest-Candidate Victim Picker

This block chooses a replacement victim for a cache whose candidate lines differ from one lookup to the next, as in skewed or hashed placement. No fixed set exists to hold ordering bits. Recency is therefore tracked with a short wrapping timestamp kept beside every line. A shared coarse clock moves forward by one each time a fixed number of cache accesses has been counted. On every hit or fill, the cache controller writes the current coarse time, which this block drives on `stamp_value`, into the stamp of the line it touched. The stamp arrays are held outside this block.

To pick a victim, the controller presents one request on a valid/ready stream. The request holds the number of candidates in use (up to `MAX_CAND`, for example 4, 16 or 52), a valid flag for each candidate and each candidate's stored stamp. The block measures each candidate's age against the coarse clock, modulo the stamp width. An empty slot always outranks any valid line. Among equals, the lowest position wins. The chosen position is returned on a second valid/ready stream.

The request stream accepts a beat when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty, or is being emptied in the same cycle (`vic_ready` high). The result appears on the cycle after acceptance. While `vic_valid` is high and `vic_ready` is low, the result holds steady, and `req_ready` stays low until the result is taken.

Top module: `tsv_victim_select`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `vic_valid` is 0 and `stamp_value` is 0. The access count also starts from zero.
- R2: `stamp_value` always shows the present coarse time. An access in a cycle sees that cycle's value, including when that access is the one that advances the clock.
- R3: After every `ACC_PER_TICK` cycles with `acc_strobe` high, the coarse time grows by exactly one on the next cycle, wrapping from 2^STAMP_W-1 to 0. It changes at no other time.
- R4: The age of valid candidate j is (time − stamp_j) mod 2^STAMP_W, using the time in the acceptance cycle. Candidate j's stamp is bits [j*STAMP_W +: STAMP_W] of `cand_stamp`. With no empty slot in range, the victim is a candidate of largest age, and `vic_age` reports that age.
- R5: When several candidates share the winning rank, the lowest position is returned.
- R6: A candidate whose bit in `cand_valid` is 0 outranks every valid candidate. The lowest such position wins, `vic_invalid` is 1 and `vic_age` is all ones. Otherwise `vic_invalid` is 0.
- R7: Only positions below `cand_count` take part, and a count above `MAX_CAND` means all of them. A count of 0 returns index 0, age 0 and `vic_invalid` 0.
- R8: An accepted request produces `vic_valid` on the next cycle, carrying that request's result.
- R9: `req_ready` equals `!vic_valid || vic_ready`. While `vic_valid` is high and `vic_ready` is low, the index, age and empty-slot flag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_strobe | input | 1 | One cache hit or fill this cycle |
| stamp_value | output | STAMP_W | Current coarse time, to be written into the touched line's stamp |
| req_valid | input | 1 | Victim request present |
| req_ready | output | 1 | Victim request can be taken |
| cand_count | input | $clog2(MAX_CAND+1) | Number of candidate positions in use |
| cand_valid | input | MAX_CAND | Per-candidate line-valid flag |
| cand_stamp | input | MAX_CAND*STAMP_W | Per-candidate stored stamp, candidate j at bits [j*STAMP_W +: STAMP_W] |
| vic_valid | output | 1 | Victim result present |
| vic_ready | input | 1 | Consumer takes the victim result |
| vic_idx | output | $clog2(MAX_CAND) | Chosen candidate position |
| vic_age | output | STAMP_W | Age of the chosen candidate (all ones for an empty slot) |
| vic_invalid | output | 1 | Chosen candidate was an empty slot |

## Verification
The hardest case to reach is an age comparison that crosses the wrap of the coarse clock. Some candidates hold stamps that are numerically above the present time but are in fact the oldest. Reaching it takes thousands of accesses, so the stimulus holds the access strobe high through long stretches. It carries the clock through several full wraps while it keeps issuing requests whose stamps sit just above and just below the current time. Back-pressure is randomised on the result stream so that requests wait while the clock moves underneath them. This checks that the age is fixed by the time in the acceptance cycle.

// File: rtl/tsv_pkg.sv
`timescale 1ns/1ps
package tsv_pkg;
  // Width of an index able to name n distinct items (at least one bit).
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
  // Width of a count that can hold the value n itself.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/tsv_time_base.sv
`timescale 1ns/1ps
module tsv_time_base #(
  parameter int STAMP_W      = 8,
  parameter int ACC_PER_TICK = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_strobe,
  output logic [STAMP_W-1:0] cur_time
);
  localparam int CW = tsv_pkg::idx_bits(ACC_PER_TICK);

  logic [CW-1:0] acc_cnt;
  logic          last_acc;

  assign last_acc = (acc_cnt == CW'(ACC_PER_TICK - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt  <= '0;
      cur_time <= '0;
    end else if (acc_strobe) begin
      if (last_acc) begin
        acc_cnt  <= '0;
        cur_time <= cur_time + STAMP_W'(1);
      end else begin
        acc_cnt <= acc_cnt + CW'(1);
      end
    end
  end

  // R3: time moves only after an access, and only by one step
  a_r3_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_time != $past(cur_time)) |->
      ($past(acc_strobe) && (cur_time == STAMP_W'($past(cur_time) + STAMP_W'(1)))));

  // R3: access counter never reaches the period
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(acc_cnt) < ACC_PER_TICK);
endmodule

// File: rtl/tsv_age_keys.sv
`timescale 1ns/1ps
module tsv_age_keys #(
  parameter int STAMP_W  = 8,
  parameter int MAX_CAND = 52,
  parameter int CNT_W    = 6,
  parameter int KEY_W    = STAMP_W + 2
) (
  input  logic [STAMP_W-1:0]          cur_time,
  input  logic [CNT_W-1:0]            cand_count,
  input  logic [MAX_CAND-1:0]         cand_valid,
  input  logic [MAX_CAND*STAMP_W-1:0] cand_stamp,
  output logic [MAX_CAND*KEY_W-1:0]   keys
);
  // Rank key per candidate: {in range, empty slot, age}.
  // Out of range gives zero; empty slot gives the top value.
  for (genvar j = 0; j < MAX_CAND; j++) begin : g_cand
    logic               in_range;
    logic [STAMP_W-1:0] age;
    assign in_range = (32'(cand_count) > j);
    assign age      = cur_time - cand_stamp[j*STAMP_W +: STAMP_W];
    always_comb begin
      if (!in_range)
        keys[j*KEY_W +: KEY_W] = '0;
      else if (!cand_valid[j])
        keys[j*KEY_W +: KEY_W] = {2'b11, {STAMP_W{1'b1}}};
      else
        keys[j*KEY_W +: KEY_W] = {2'b10, age};
    end
  end
endmodule

// File: rtl/tsv_oldest_tree.sv
`timescale 1ns/1ps
module tsv_oldest_tree #(
  parameter int N     = 52,
  parameter int KEY_W = 10,
  parameter int IW    = 6
) (
  input  logic [N*KEY_W-1:0] keys,
  output logic [KEY_W-1:0]   win_key,
  output logic [IW-1:0]      win_idx
);
  localparam int LV     = (N <= 1) ? 0 : $clog2(N);
  localparam int LEAVES = 1 << LV;
  localparam int NODES  = 2 * LEAVES - 1;

  // Heap layout: node i has children 2i+1 (lower positions) and 2i+2.
  logic [KEY_W-1:0] nk [NODES];
  logic [IW-1:0]    ni [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < N) begin : g_real
      assign nk[LEAVES-1+j] = keys[j*KEY_W +: KEY_W];
    end else begin : g_pad
      assign nk[LEAVES-1+j] = '0;
    end
    assign ni[LEAVES-1+j] = IW'(j);
  end

  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
    logic take_hi;
    // Upper half wins only when strictly older: ties keep the lower position.
    assign take_hi = nk[2*i+2] > nk[2*i+1];
    assign nk[i]   = take_hi ? nk[2*i+2] : nk[2*i+1];
    assign ni[i]   = take_hi ? ni[2*i+2] : ni[2*i+1];
  end

  assign win_key = nk[0];
  assign win_idx = ni[0];
endmodule

// File: rtl/tsv_victim_select.sv
`timescale 1ns/1ps
module tsv_victim_select #(
  parameter int STAMP_W      = 8,
  parameter int ACC_PER_TICK = 5,
  parameter int MAX_CAND     = 52
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     acc_strobe,
  output logic [STAMP_W-1:0]                       stamp_value,
  input  logic                                     req_valid,
  output logic                                     req_ready,
  input  logic [tsv_pkg::cnt_bits(MAX_CAND)-1:0]   cand_count,
  input  logic [MAX_CAND-1:0]                      cand_valid,
  input  logic [MAX_CAND*STAMP_W-1:0]              cand_stamp,
  output logic                                     vic_valid,
  input  logic                                     vic_ready,
  output logic [tsv_pkg::idx_bits(MAX_CAND)-1:0]   vic_idx,
  output logic [STAMP_W-1:0]                       vic_age,
  output logic                                     vic_invalid
);
  localparam int IW    = tsv_pkg::idx_bits(MAX_CAND);
  localparam int CNT_W = tsv_pkg::cnt_bits(MAX_CAND);
  localparam int KEY_W = STAMP_W + 2;

  logic [STAMP_W-1:0]        cur_time;
  logic [MAX_CAND*KEY_W-1:0] keys;
  logic [KEY_W-1:0]          win_key;
  logic [IW-1:0]             win_idx;
  logic                      accept;

  tsv_time_base #(.STAMP_W(STAMP_W), .ACC_PER_TICK(ACC_PER_TICK)) u_time (
    .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .cur_time(cur_time)
  );

  tsv_age_keys #(.STAMP_W(STAMP_W), .MAX_CAND(MAX_CAND), .CNT_W(CNT_W), .KEY_W(KEY_W)) u_keys (
    .cur_time(cur_time), .cand_count(cand_count), .cand_valid(cand_valid),
    .cand_stamp(cand_stamp), .keys(keys)
  );

  tsv_oldest_tree #(.N(MAX_CAND), .KEY_W(KEY_W), .IW(IW)) u_tree (
    .keys(keys), .win_key(win_key), .win_idx(win_idx)
  );

  assign stamp_value = cur_time;
  assign req_ready   = !vic_valid || vic_ready;
  assign accept      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic_valid   <= 1'b0;
      vic_idx     <= '0;
      vic_age     <= '0;
      vic_invalid <= 1'b0;
    end else if (accept) begin
      vic_valid   <= 1'b1;
      vic_idx     <= win_idx;
      vic_age     <= win_key[STAMP_W-1:0];
      vic_invalid <= win_key[STAMP_W+1] & win_key[STAMP_W];
    end else if (vic_ready) begin
      vic_valid <= 1'b0;
    end
  end

  // R9: a stalled result does not move
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !vic_ready) |=>
      (vic_valid && $stable(vic_idx) && $stable(vic_age) && $stable(vic_invalid)));

  // R8: an accepted request yields a result next cycle
  a_r8_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> vic_valid);

  // R7: returned index names a real position
  a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> (32'(vic_idx) < MAX_CAND));

  // R4 / R5: winner outranks every candidate; equal ranks sit at higher positions
  for (genvar j = 0; j < MAX_CAND; j++) begin : g_chk
    a_r5_first_max: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> ((keys[j*KEY_W +: KEY_W] <= win_key) &&
                  ((keys[j*KEY_W +: KEY_W] != win_key) || (IW'(j) >= win_idx))));
  end
endmodule

// File: tb/test_tsv_victim_select.sv
`timescale 1ns/1ps
module test_tsv_victim_select;
  localparam int W  = 8;
  localparam int K  = 5;
  localparam int M  = 52;
  localparam int IW = 6;
  localparam int CW = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           acc_strobe = 1'b0;
  logic [W-1:0]   stamp_value;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [CW-1:0]  cand_count = '0;
  logic [M-1:0]   cand_valid = '1;
  logic [M*W-1:0] cand_stamp = '0;
  logic           vic_valid;
  logic           vic_ready = 1'b1;
  logic [IW-1:0]  vic_idx;
  logic [W-1:0]   vic_age;
  logic           vic_invalid;

  always #2 clk = ~clk;

  tsv_victim_select #(.STAMP_W(W), .ACC_PER_TICK(K), .MAX_CAND(M)) i_tsv_victim_select (
    .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .stamp_value(stamp_value),
    .req_valid(req_valid), .req_ready(req_ready), .cand_count(cand_count),
    .cand_valid(cand_valid), .cand_stamp(cand_stamp), .vic_valid(vic_valid),
    .vic_ready(vic_ready), .vic_idx(vic_idx), .vic_age(vic_age), .vic_invalid(vic_invalid)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;

  // Reference model state
  int    m_time = 0;
  int    m_cnt  = 0;
  bit    m_vv   = 0;
  int    m_idx  = 0;
  int    m_age  = 0;
  bit    m_inv  = 0;
  string m_tag  = "R7";
  int    m_cyc  = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic ref_pick(input int t, input int cnt, input logic [M-1:0] v,
                          input logic [M*W-1:0] s, output int idx, output int age,
                          output bit inv, output string tag);
    int lim;
    int best;
    idx = 0; age = 0; inv = 0; tag = "R7"; best = -1;
    lim = (cnt > M) ? M : cnt;
    for (int j = 0; j < lim; j++) begin
      if (!v[j]) begin
        if (!inv) begin inv = 1; idx = j; age = 255; tag = "R6"; end
        else tag = "R6";
      end
    end
    if (!inv) begin
      for (int j = 0; j < lim; j++) begin
        int a;
        a = (t - int'(s[j*W +: W]) + 256) % 256;
        if (a > best) begin best = a; idx = j; age = a; tag = "R4"; end
        else if (a == best) tag = "R5";
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_time = 0; m_cnt = 0; m_vv = 0; m_idx = 0; m_age = 0; m_inv = 0; m_cyc = 0;
    end else begin
      m_cyc++;
      if (!m_vv || vic_ready) begin
        m_vv = req_valid;
        if (req_valid) ref_pick(m_time, int'(cand_count), cand_valid, cand_stamp, m_idx, m_age, m_inv, m_tag);
      end
      if (acc_strobe) begin
        if (m_cnt == K - 1) begin m_cnt = 0; m_time = (m_time + 1) % 256; end
        else m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (!done) begin
      if (!rst_n || m_cyc == 1) begin
        chk(stamp_value == '0, "R1", "stamp_value", int'(stamp_value), 0);
        chk(vic_valid == 1'b0, "R1", "vic_valid", int'(vic_valid), 0);
      end else begin
        chk(int'(stamp_value) == m_time, (acc_strobe && m_cnt == K - 1) ? "R2" : "R3",
            "stamp_value", int'(stamp_value), m_time);
        chk(vic_valid == m_vv, "R8", "vic_valid", int'(vic_valid), int'(m_vv));
        chk(req_ready == (!m_vv || vic_ready), "R9", "req_ready", int'(req_ready), int'(!m_vv || vic_ready));
        if (m_vv) begin
          chk(int'(vic_idx) == m_idx, m_tag, "vic_idx", int'(vic_idx), m_idx);
          chk(int'(vic_age) == m_age, m_tag, "vic_age", int'(vic_age), m_age);
          chk(vic_invalid == m_inv, m_tag, "vic_invalid", int'(vic_invalid), int'(m_inv));
        end
      end
    end
  end

  // Stamps spread behind the present time; some placed just ahead (wrapped oldest).
  task automatic fill_stamps(input int spread);
    for (int j = 0; j < M; j++) begin
      int r;
      r = int'($urandom % 8);
      if (r == 0) cand_stamp[j*W +: W] = W'(m_time + 1 + int'($urandom % 3));
      else        cand_stamp[j*W +: W] = W'(m_time - int'($urandom % spread));
    end
  endtask

  task automatic one_req(input int cnt);
    cand_count = CW'(cnt);
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid  = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: distinct ages among four candidates
    cand_valid = '1;
    for (int j = 0; j < M; j++) cand_stamp[j*W +: W] = W'(200 - j);
    cand_stamp[2*W +: W] = W'(100);
    one_req(4);
    // R5: equal oldest stamps at positions 1 and 3
    cand_stamp[1*W +: W] = W'(50); cand_stamp[3*W +: W] = W'(50);
    one_req(4);
    // R6: two empty slots, lower one must win
    cand_valid[9] = 1'b0; cand_valid[5] = 1'b0;
    one_req(16);
    // R7: empty slot beyond the count is ignored
    one_req(5);
    // R7: zero count
    one_req(0);
    // R7: count above maximum behaves as full
    cand_valid = '1; cand_valid[51] = 1'b0;
    one_req(63);
    one_req(52);
    cand_valid = '1;

    // R9: stalled result while new request waits
    vic_ready = 1'b0;
    cand_count = CW'(16);
    req_valid = 1'b1;
    @(negedge clk);
    fill_stamps(30);
    repeat (4) @(negedge clk);
    vic_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);

    // R2/R3: run the clock through several wraps with requests in flight
    acc_strobe = 1'b1;
    for (int c = 0; c < 4200; c++) begin
      fill_stamps(200);
      req_valid  = ($urandom % 3) != 0;
      vic_ready  = ($urandom % 4) != 0;
      cand_count = CW'(((c % 3) == 0) ? 4 : ((c % 3) == 1) ? 16 : 52);
      @(negedge clk);
    end

    // Mixed random traffic
    for (int c = 0; c < 3000; c++) begin
      acc_strobe = ($urandom % 4) != 0;
      req_valid  = ($urandom % 2) != 0;
      vic_ready  = ($urandom % 3) != 0;
      cand_count = CW'($urandom % 64);
      cand_valid = '1;
      if (($urandom % 5) == 0) cand_valid[$urandom % M] = 1'b0;
      fill_stamps(1 + int'($urandom % 255));
      if (($urandom % 6) == 0) cand_stamp[(3*W) +: W] = cand_stamp[(1*W) +: W];
      @(negedge clk);
    end
    req_valid = 1'b0; vic_ready = 1'b1; acc_strobe = 1'b0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule